// File: doc/BRIEF.md
# DDR SDRAM Four-Bank Command Sequencer

This block sits between a host request port and the command pins of a double data rate SDRAM. The host presents one access at a time (direction, bank, row, column, and an optional close-after-burst flag) and holds it until the block accepts it. The block tracks which row is open in each of the four banks. It opens a closed bank with an ACTIVATE and closes a bank holding the wrong row with a PRECHARGE. The READ or WRITE is issued only once the target row is open. Every command leaves the block from a register, so the bus changes only on the rising clock edge.

A single gap counter spaces the commands. Each issued command loads the number of idle cycles it needs: row-open delay, precharge time, refresh recovery, the burst length in clock cycles, and a write-to-read turnaround. A periodic timer, derived from the clock frequency, raises a refresh request about every 7.8 us (4096 refreshes per 32 ms). Once raised, the request outranks host traffic. If any bank is open, the block first closes all banks with one command and then issues the refresh. A read-data-valid flag marks the clock cycles in which read data is due, following the programmed CAS latency.

Top module: `ddr_cmd_sched`

## Requirements
- R1: While reset is low at a clock edge, the command bus shows NOP (code 0) in the following cycle, and `rd_valid` and `req_ready` are low.
- R2: A request to a bank with no open row first issues ACTIVATE (code 1) with the row on `cmd_addr`. The READ (code 2) or WRITE (code 3) with the column follows exactly T_RCD cycles later.
- R3: A request whose row is already open in its bank issues READ or WRITE directly, with no ACTIVATE or PRECHARGE before it.
- R4: A request to a bank holding a different row issues PRECHARGE (code 4) to that bank, then ACTIVATE T_RP cycles later, then the access T_RCD cycles after that.
- R5: An access with `req_ap` set drives `cmd_ap` high and leaves its bank closed. The next request to that bank starts with ACTIVATE, no earlier than burst cycles plus T_RP after the access.
- R6: `cfg_cl4` selects CAS latency 4 when 1 and 3 when 0. `rd_valid` rises exactly CAS-latency cycles after a READ appears on the bus.
- R7: `cfg_bl` encodes the burst as 00 = 2, 01 = 4, 1x = 8 beats, which take 1, 2 or 4 clock cycles. `rd_valid` stays high for that many cycles, and consecutive reads are spaced by exactly that many cycles, so no burst is cut short.
- R8: A READ that follows a WRITE is issued no earlier than the write burst cycles plus T_WTR, so a read never interrupts a write burst.
- R9: With no access in progress and all banks closed, AUTO REFRESH (code 6) is issued every REFRESH_CYCLES = CLK_MHZ*15625/2000 cycles. If any bank is open, a close-all precharge (code 5) is issued first and the refresh follows T_RP cycles later.
- R10: A pending refresh wins over a host request offered in the same cycle. The request's first command follows the refresh after exactly T_RFC cycles.
- R11: `req_ready` is high in exactly the cycle before the accepted request's READ or WRITE appears on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cl4 | input | 1 | CAS latency select: 0 = 3, 1 = 4 |
| cfg_bl | input | 2 | Burst length: 00 = 2, 01 = 4, 1x = 8 |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Close the bank after this burst |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_ready | output | 1 | Request accepted at this edge |
| cmd_o | output | 3 | Command code: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 PRE-all, 6 REF |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | max(ROW_W,COL_W) | Row for ACT, column for RD/WR |
| cmd_ap | output | 1 | Auto-precharge flag (also set for PRE-all) |
| rd_valid | output | 1 | Read data due in this cycle |

## Verification
The refresh timer and a host request can fall into the same decision cycle. The bench provokes this by timing the request from two back-to-back idle refreshes, so that the request first appears in the very cycle the next refresh becomes pending. It judges the result from the bus order: the refresh must come out first at the predicted cycle, and the request's ACTIVATE must follow exactly the recovery time later. A second overlap is a pending refresh meeting open banks. That case is judged by finding the close-all precharge exactly T_RP cycles before the refresh.

// File: rtl/dsch_pkg.sv
// Shared command codes and burst helper for the DDR command sequencer.
// Assumes the command code values are fixed by the bus consumer.
package dsch_pkg;
    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_PREA = 3'd5,
        CMD_REF  = 3'd6
    } cmd_e;

    // Clock cycles occupied by one burst for a given burst-length code.
    function automatic logic [2:0] beats_of(input logic [1:0] bl);
        case (bl)
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/dsch_bank_table.sv
// Open-row table: one open flag and one row register per bank.
// Looks up the requested bank combinationally and reports a row hit.
// Assumes set and clear never target the same bank in one cycle.
module dsch_bank_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    input  logic              set_en,
    input  logic [BANK_W-1:0] set_bank,
    input  logic [ROW_W-1:0]  set_row,
    input  logic              clr_en,
    input  logic [BANK_W-1:0] clr_bank,
    input  logic              clr_all,
    output logic              lk_open,
    output logic              lk_hit,
    output logic              any_open
);
    localparam int NB = 1 << BANK_W;

    logic [NB-1:0]    open_q;
    logic [ROW_W-1:0] row_q [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic             open_r;
        logic [ROW_W-1:0] row_r;
        // Track open state and row of bank b.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_r <= 1'b0;
                row_r  <= '0;
            end else if (clr_all) begin
                open_r <= 1'b0;
            end else if (set_en && set_bank == BANK_W'(b)) begin
                open_r <= 1'b1;
                row_r  <= set_row;
            end else if (clr_en && clr_bank == BANK_W'(b)) begin
                open_r <= 1'b0;
            end
        end
        assign open_q[b] = open_r;
        assign row_q[b]  = row_r;
    end

    assign lk_open  = open_q[lk_bank];
    assign lk_hit   = lk_open && (row_q[lk_bank] == lk_row);
    assign any_open = |open_q;

    // R2: an activate only ever targets a bank that is closed.
    p_act_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !open_q[set_bank]);
    // R5: a bank closed by auto-precharge reads as closed afterwards.
    p_clr_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en && !clr_all) |=> !open_q[$past(clr_bank)]);
endmodule

// File: rtl/dsch_ref_timer.sv
// Periodic refresh request: free-running countdown that raises a pending
// flag at each expiry; the flag drops when the refresh is issued.
// Assumes INTERVAL is far larger than any refresh sequence.
module dsch_ref_timer #(
    parameter int INTERVAL = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_done,
    output logic ref_pend
);
    localparam int CW = $clog2(INTERVAL + 1);
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    // Count down the interval and latch a refresh request at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= RELOAD;
            ref_pend <= 1'b0;
        end else begin
            cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
            if (cnt_q == '0)
                ref_pend <= 1'b1;
            else if (ref_done)
                ref_pend <= 1'b0;
        end
    end

    // R9: issuing the refresh clears the request.
    p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_done && cnt_q != '0) |=> !ref_pend);
    // R9: a refresh is only issued when one is pending.
    p_done_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |-> ref_pend);
endmodule

// File: rtl/dsch_rd_valid.sv
// Read-data-valid generator: shifts a marker per READ on the bus and
// flags the window [CL, CL+beats-1] cycles after it.
// Assumes reads are spaced at least one burst apart.
module dsch_rd_valid #(
    parameter int MAX_LAT   = 4,
    parameter int MAX_BEATS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_issued,
    input  logic       cl4,
    input  logic [2:0] beats,
    output logic       rd_valid
);
    localparam int DEPTH = MAX_LAT + MAX_BEATS - 1;

    logic [DEPTH-1:0] sr_q;
    int               lat_c;
    int               bt_c;

    // Age each READ marker by one cycle per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[DEPTH-2:0], rd_issued};
    end

    // Raise valid when any marker is inside its data window.
    always_comb begin
        lat_c    = cl4 ? 4 : 3;
        bt_c     = int'(beats);
        rd_valid = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (sr_q[i] && i >= lat_c - 1 && i < lat_c - 1 + bt_c)
                rd_valid = 1'b1;
    end

    // R6: data window opens exactly three cycles after a READ at CL3.
    p_rdv_cl3_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_valid) && !cl4) |-> $past(rd_issued, 3));
    // R6: data window opens exactly four cycles after a READ at CL4.
    p_rdv_cl4_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_valid) && cl4) |-> $past(rd_issued, 4));
endmodule

// File: rtl/ddr_cmd_sched.sv
// Four-bank DDR SDRAM command sequencer. Decides one command per free
// cycle (refresh first, then the host request), registers it onto the
// command bus and loads a gap counter with the idle time it needs.
// Assumes configuration inputs change only while no access is in flight.
module ddr_cmd_sched
    import dsch_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 12,
    parameter int COL_W   = 9,
    parameter int CLK_MHZ = 100,
    parameter int T_RCD   = 3,
    parameter int T_RP    = 3,
    parameter int T_RFC   = 10,
    parameter int T_WTR   = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_cl4,
    input  logic [1:0]                         cfg_bl,
    input  logic                               req_valid,
    input  logic                               req_write,
    input  logic                               req_ap,
    input  logic [BANK_W-1:0]                  req_bank,
    input  logic [ROW_W-1:0]                   req_row,
    input  logic [COL_W-1:0]                   req_col,
    output logic                               req_ready,
    output logic [2:0]                         cmd_o,
    output logic [BANK_W-1:0]                  cmd_bank,
    output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0] cmd_addr,
    output logic                               cmd_ap,
    output logic                               rd_valid
);
    localparam int ADDR_W       = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int REF_INTERVAL = (CLK_MHZ * 15625) / 2000;
    localparam int WAIT_W       = $clog2(T_RFC + T_RP + T_WTR + 8);

    cmd_e              cmd_q, nxt_cmd;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] addr_q, nxt_addr;
    logic              ap_q, nxt_ap;
    logic [WAIT_W-1:0] wait_q, nxt_wait, acc_gap;
    logic [2:0]        beats;
    logic              lk_open, lk_hit, any_open;
    logic              set_en, clr_en, clr_all;
    logic              ref_pend, ref_done;

    assign beats = beats_of(cfg_bl);

    dsch_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .lk_bank(req_bank), .lk_row(req_row),
        .set_en(set_en), .set_bank(req_bank), .set_row(req_row),
        .clr_en(clr_en), .clr_bank(req_bank), .clr_all(clr_all),
        .lk_open(lk_open), .lk_hit(lk_hit), .any_open(any_open)
    );

    dsch_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk(clk), .rst_n(rst_n), .ref_done(ref_done), .ref_pend(ref_pend)
    );

    dsch_rd_valid #(.MAX_LAT(4), .MAX_BEATS(4)) u_rdv (
        .clk(clk), .rst_n(rst_n), .rd_issued(cmd_q == CMD_RD),
        .cl4(cfg_cl4), .beats(beats), .rd_valid(rd_valid)
    );

    // Idle cycles an access needs: burst, write turnaround, self-close.
    always_comb begin
        acc_gap = WAIT_W'(beats);
        if (req_write) acc_gap = acc_gap + WAIT_W'(T_WTR);
        if (req_ap)    acc_gap = acc_gap + WAIT_W'(T_RP);
    end

    // Pick the next command: refresh first, then the host request.
    always_comb begin
        nxt_cmd   = CMD_NOP;
        nxt_addr  = '0;
        nxt_ap    = 1'b0;
        nxt_wait  = WAIT_W'(1);
        req_ready = 1'b0;
        set_en    = 1'b0;
        clr_en    = 1'b0;
        clr_all   = 1'b0;
        ref_done  = 1'b0;
        if (wait_q == '0) begin
            if (ref_pend) begin
                if (any_open) begin
                    nxt_cmd  = CMD_PREA;
                    nxt_ap   = 1'b1;
                    clr_all  = 1'b1;
                    nxt_wait = WAIT_W'(T_RP);
                end else begin
                    nxt_cmd  = CMD_REF;
                    ref_done = 1'b1;
                    nxt_wait = WAIT_W'(T_RFC);
                end
            end else if (req_valid) begin
                if (lk_hit) begin
                    nxt_cmd   = req_write ? CMD_WR : CMD_RD;
                    nxt_addr  = ADDR_W'(req_col);
                    nxt_ap    = req_ap;
                    clr_en    = req_ap;
                    req_ready = 1'b1;
                    nxt_wait  = acc_gap;
                end else if (lk_open) begin
                    nxt_cmd  = CMD_PRE;
                    clr_en   = 1'b1;
                    nxt_wait = WAIT_W'(T_RP);
                end else begin
                    nxt_cmd  = CMD_ACT;
                    nxt_addr = ADDR_W'(req_row);
                    set_en   = 1'b1;
                    nxt_wait = WAIT_W'(T_RCD);
                end
            end
        end
    end

    // Register the command bus and run the gap counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            addr_q <= '0;
            ap_q   <= 1'b0;
            wait_q <= '0;
        end else begin
            cmd_q  <= nxt_cmd;
            bank_q <= req_bank;
            addr_q <= nxt_addr;
            ap_q   <= nxt_ap;
            if (nxt_cmd != CMD_NOP)
                wait_q <= nxt_wait - 1'b1;
            else if (wait_q != '0)
                wait_q <= wait_q - 1'b1;
        end
    end

    assign cmd_o    = cmd_q;
    assign cmd_bank = bank_q;
    assign cmd_addr = addr_q;
    assign cmd_ap   = ap_q;

    // R1: reset drives the bus idle.
    p_reset_nop_r1: assert property (@(posedge clk)
        !rst_n |=> cmd_o == 3'd0);
    // R11: acceptance is followed by the access on the bus.
    p_ready_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> (cmd_o == 3'd2 || cmd_o == 3'd3));
    // R7: a burst longer than one cycle is never cut by the next command.
    p_burst_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_q == CMD_RD || cmd_q == CMD_WR) && cfg_bl != 2'b00) |=> cmd_q == CMD_NOP);
    // R9: refresh goes out only with every bank closed.
    p_ref_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q == CMD_REF |-> !any_open);
    // R10: refresh recovery keeps the next cycle idle.
    p_ref_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q == CMD_REF |=> cmd_q == CMD_NOP);
endmodule

// File: tb/ddr_cmd_sched_tb.sv
// Directed bench: one task per scenario, each checking its own results
// against timing computed from the requirements.
module ddr_cmd_sched_tb;
    localparam int T_RCD = 3, T_RP = 3, T_RFC = 10, T_WTR = 2;
    localparam int REF_N = (100 * 15625) / 2000;
    localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_PREA = 5, C_REF = 6;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_cl4 = 1'b0;
    logic [1:0]  cfg_bl = 2'b01;
    logic        req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic        req_ready, cmd_ap, rd_valid;
    logic [2:0]  cmd_o;
    logic [1:0]  cmd_bank;
    logic [11:0] cmd_addr;

    int cyc = 0, n_chk = 0, n_err = 0, ready_cyc = 0;
    int lg_n = 0, rv_n = 0;
    int lg_cmd [64], lg_cyc [64], lg_bank [64], lg_addr [64], lg_ap [64], rv_cyc [64];

    ddr_cmd_sched u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_cl4(cfg_cl4), .cfg_bl(cfg_bl),
        .req_valid(req_valid), .req_write(req_write), .req_ap(req_ap),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_ready(req_ready), .cmd_o(cmd_o), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .cmd_ap(cmd_ap), .rd_valid(rd_valid)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Log bus commands and read-valid cycles, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_o != 3'd0 && lg_n < 64) begin
                lg_cmd[lg_n] = int'(cmd_o); lg_cyc[lg_n] = cyc;
                lg_bank[lg_n] = int'(cmd_bank); lg_addr[lg_n] = int'(cmd_addr);
                lg_ap[lg_n] = int'(cmd_ap); lg_n = lg_n + 1;
            end
            if (rd_valid && rv_n < 64) begin
                rv_cyc[rv_n] = cyc; rv_n = rv_n + 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        @(negedge clk); #1;
        lg_n = 0; rv_n = 0;
    endtask

    task automatic do_req(input bit w, input bit ap, input int bank, input int row, input int col);
        int guard = 0;
        req_write = w; req_ap = ap; req_bank = 2'(bank);
        req_row = 12'(row); req_col = 9'(col); req_valid = 1'b1;
        #1;
        while (!req_ready && guard < 3000) begin
            @(negedge clk); #1; guard++;
        end
        ready_cyc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_ref(output int t);
        int guard = 0;
        t = -1;
        while (t < 0 && guard < 3000) begin
            @(negedge clk); #1; guard++;
            if (cmd_o == 3'(C_REF)) t = cyc;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 cmd in reset", int'(cmd_o), C_NOP);
        chk("R1 rd_valid in reset", int'(rd_valid), 0);
        chk("R1 req_ready in reset", int'(req_ready), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_closed_read();
        cfg_cl4 = 1'b0; cfg_bl = 2'b01;
        clear_logs();
        do_req(0, 0, 0, 5, 8);
        repeat (10) @(negedge clk);
        chk("R2 first cmd ACT", lg_cmd[0], C_ACT);
        chk("R2 ACT row", lg_addr[0], 5);
        chk("R2 second cmd RD", lg_cmd[1], C_RD);
        chk("R2 RD column", lg_addr[1], 8);
        chk("R2 ACT to RD gap", lg_cyc[1] - lg_cyc[0], T_RCD);
        chk("R11 ready one cycle before RD", lg_cyc[1] - ready_cyc, 1);
        chk("R6 CL3 valid start", rv_cyc[0] - lg_cyc[1], 3);
        chk("R7 BL4 valid length", rv_n, 2);
    endtask

    task automatic t_hit_read();
        cfg_cl4 = 1'b1; cfg_bl = 2'b10;
        clear_logs();
        do_req(0, 0, 0, 5, 9);
        repeat (12) @(negedge clk);
        chk("R3 hit issues RD directly", lg_cmd[0], C_RD);
        chk("R3 single command", lg_n, 1);
        chk("R6 CL4 valid start", rv_cyc[0] - lg_cyc[0], 4);
        chk("R7 BL8 valid length", rv_n, 4);
        chk("R7 BL8 valid contiguous", rv_cyc[3] - rv_cyc[0], 3);
    endtask

    task automatic t_row_miss();
        cfg_bl = 2'b01;
        clear_logs();
        do_req(1, 0, 0, 7, 3);
        repeat (6) @(negedge clk);
        chk("R4 first cmd PRE", lg_cmd[0], C_PRE);
        chk("R4 PRE bank", lg_bank[0], 0);
        chk("R4 then ACT", lg_cmd[1], C_ACT);
        chk("R4 PRE to ACT gap", lg_cyc[1] - lg_cyc[0], T_RP);
        chk("R4 ACT new row", lg_addr[1], 7);
        chk("R4 then WR", lg_cmd[2], C_WR);
        chk("R4 ACT to WR gap", lg_cyc[2] - lg_cyc[1], T_RCD);
    endtask

    task automatic t_spacing();
        cfg_bl = 2'b01;
        clear_logs();
        do_req(1, 0, 0, 7, 4);
        do_req(0, 0, 0, 7, 5);
        repeat (6) @(negedge clk);
        chk("R8 WR then RD", lg_cmd[1], C_RD);
        chk("R8 write-to-read gap", lg_cyc[1] - lg_cyc[0], 2 + T_WTR);
        cfg_bl = 2'b10;
        clear_logs();
        do_req(0, 0, 0, 7, 6);
        do_req(0, 0, 0, 7, 7);
        repeat (6) @(negedge clk);
        chk("R7 BL8 read-to-read gap", lg_cyc[1] - lg_cyc[0], 4);
        cfg_bl = 2'b00;
        clear_logs();
        do_req(0, 0, 0, 7, 8);
        do_req(0, 0, 0, 7, 9);
        repeat (6) @(negedge clk);
        chk("R7 BL2 read-to-read gap", lg_cyc[1] - lg_cyc[0], 1);
    endtask

    task automatic t_auto_pre();
        cfg_bl = 2'b00;
        clear_logs();
        do_req(0, 1, 1, 20, 2);
        do_req(0, 0, 1, 20, 6);
        repeat (6) @(negedge clk);
        chk("R5 access carries ap", lg_ap[1], 1);
        chk("R5 reopen with ACT", lg_cmd[2], C_ACT);
        chk("R5 burst plus precharge gap", lg_cyc[2] - lg_cyc[1], 1 + T_RP);
        chk("R5 then RD", lg_cmd[3], C_RD);
    endtask

    task automatic t_ref_open();
        int t;
        do_req(0, 0, 2, 1, 0);
        clear_logs();
        wait_ref(t);
        chk("R9 close-all before REF", lg_cmd[lg_n - 2], C_PREA);
        chk("R9 close-all to REF gap", t - lg_cyc[lg_n - 2], T_RP);
    endtask

    task automatic t_ref_collide();
        int t2, t3;
        wait_ref(t2);
        wait_ref(t3);
        chk("R9 idle refresh period", t3 - t2, REF_N);
        lg_n = 0; rv_n = 0;
        while (cyc < t3 + REF_N - 1) @(negedge clk);
        do_req(0, 0, 3, 9, 1);
        repeat (4) @(negedge clk);
        chk("R10 refresh wins", lg_cmd[0], C_REF);
        chk("R10 refresh cycle", lg_cyc[0] - t3, REF_N);
        chk("R10 request ACT after refresh", lg_cmd[1], C_ACT);
        chk("R10 refresh recovery gap", lg_cyc[1] - lg_cyc[0], T_RFC);
    endtask

    initial begin
        int t0;
        t_reset();
        wait_ref(t0);
        repeat (T_RFC + 2) @(negedge clk);
        t_closed_read();
        t_hit_read();
        t_row_miss();
        t_spacing();
        t_auto_pre();
        t_ref_open();
        t_ref_collide();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule